// File: doc/BRIEF.md
# Masked ASID-Tagged Translation Lookup Array

This block is a small fully associative translation array. Each slot stores a virtual page number, a page-size mask, an address-space tag, a global flag, an even-page and an odd-page valid bit, and two physical frame numbers. A lookup presents a virtual address and an address-space tag. The same cycle's combinational result gives a hit flag, the slot number that matched (a probe result), and the frame numbers of that slot. The address itself is also decoded into an uncacheable flag and, for instruction fetches, an alignment fault.

Software or a refill engine fills the array through an indexed write port. A flush strobe empties the whole array. A round-robin victim pointer names the slot to replace next. It advances when the pointer is consumed and wraps at the last slot. Miss handling, refill and page walking sit outside this block.

Top module: `masked_tlb_array`

## Requirements
- R1: The lookup page number is `lk_vaddr[31:13]`. A slot compares it with its stored page number only on the bit positions where its mask bit is 0. Mask bits set to 1 are don't-care.
- R2: The address-space test passes when the slot's global flag is 1 or when `lk_asid` equals the stored tag.
- R3: `hit_idx` carries the lowest-numbered matching slot, zero-extended. It is all ones (-1 as a signed value) when no slot matches. This probe result is reported even when an alignment fault suppresses `hit`.
- R4: A slot is valid when at least one of its two valid bits is 1. A slot with both valid bits at 0 never matches, whatever its page number or tag.
- R5: A write with `wr_idx` at or above the slot count leaves every slot unchanged. An in-range write replaces all fields of the addressed slot at the next clock edge.
- R6: A flush empties every slot and sets the victim pointer to 0 at the next clock edge. Flush takes priority over a write or an advance in the same cycle.
- R7: The victim pointer starts at 0 after reset. It increments by one at each edge where `vic_adv` is 1, wraps from the last slot to 0, and otherwise holds.
- R8: When `lk_ifetch` is 1 and either of `lk_vaddr[1:0]` is 1, `align_fault` is 1 and `hit` is 0. `align_fault` is 0 otherwise.
- R9: `uncacheable` is 1 exactly when bits 31 and 29 of `lk_vaddr` are both 1.
- R10: On a hit, `pfn0` and `pfn1` carry the frame numbers of the slot named by `hit_idx`. When `hit` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | 4 | Write slot number (values of 8 and above are ignored) |
| wr_vpn | input | 19 | Page number to store |
| wr_mask | input | 19 | Page-size mask to store (1 = don't care) |
| wr_asid | input | 8 | Address-space tag to store |
| wr_glob | input | 1 | Global flag to store |
| wr_v0 | input | 1 | Even-page valid bit |
| wr_v1 | input | 1 | Odd-page valid bit |
| wr_pfn0 | input | 20 | Even-page frame number |
| wr_pfn1 | input | 20 | Odd-page frame number |
| flush | input | 1 | Empty the whole array |
| vic_adv | input | 1 | Consume the victim pointer and advance it |
| hit | output | 1 | Lookup hit, with no fault |
| hit_idx | output | 4 | Matching slot, or all ones on a miss |
| pfn0 | output | 20 | Even frame number of the hit slot |
| pfn1 | output | 20 | Odd frame number of the hit slot |
| uncacheable | output | 1 | Address lies in the uncacheable region |
| align_fault | output | 1 | Misaligned instruction fetch |
| victim_idx | output | 3 | Next slot to replace |

## Verification
The hardest case to reach from the ports is several valid slots matching one lookup at once, through different masks, global flags and tags. Only then does the lowest-index rule of the priority encoder decide the result. Random stimulus draws only a few tag values and short masks over a small page-number space. This makes overlapping slots frequent. Directed cases also plant a wide-mask global slot above a narrow exact slot, and write the same page into two slots, so the priority is exercised on purpose.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  parameter int VA_W   = 32;
  parameter int PAGE_W = 13;
  parameter int VPN_W  = VA_W - PAGE_W;
  parameter int ASID_W = 8;
  parameter int PFN_W  = 20;
  parameter logic [VA_W-1:0] UNC_PAT = 32'hA000_0000;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic              v0;
    logic              v1;
    logic [PFN_W-1:0]  pfn0;
    logic [PFN_W-1:0]  pfn1;
  } tlb_ent_t;

  // A slot answers when valid, the unmasked page bits agree, and the tag test passes.
  function automatic logic ent_match(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                     logic [ASID_W-1:0] asid);
    logic page_ok, tag_ok;
    page_ok = (((vpn ^ e.vpn) & ~e.mask) == '0);
    tag_ok  = e.glob || (asid == e.asid);
    return (e.v0 | e.v1) & page_ok & tag_ok;
  endfunction

  function automatic logic is_uncached(logic [VA_W-1:0] va);
    return (va & UNC_PAT) == UNC_PAT;
  endfunction

  function automatic logic misaligned(logic [VA_W-1:0] va);
    return va[1] | va[0];
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlbx_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDXW = $clog2(N_ENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [IDXW:0]         wr_idx,
  input  tlb_ent_t              wr_ent,
  output tlb_ent_t [N_ENT-1:0]  tab
);
  logic wr_inrange;
  assign wr_inrange = wr_en && (int'(wr_idx) < N_ENT);

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    logic sel;
    assign sel = wr_inrange && (int'(wr_idx) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tab[g] <= '0;
      else if (flush)  tab[g] <= '0;
      else if (sel)    tab[g] <= wr_ent;
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlbx_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDXW = $clog2(N_ENT)
) (
  input  tlb_ent_t [N_ENT-1:0] tab,
  input  logic [VPN_W-1:0]     vpn,
  input  logic [ASID_W-1:0]    asid,
  output logic                 any,
  output logic [IDXW-1:0]      idx
);
  logic [N_ENT-1:0] hv;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hv[g] = ent_match(tab[g], vpn, asid);
  end

  assign any = |hv;

  // Fixed priority: scanning downward leaves the lowest match in idx.
  always_comb begin
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (hv[i]) idx = IDXW'(i);
  end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int N_ENT = 8,
  localparam int IDXW = $clog2(N_ENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            adv,
  output logic [IDXW-1:0] ptr
);
  logic at_last;
  assign at_last = (int'(ptr) == N_ENT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (flush) ptr <= '0;
    else if (adv)   ptr <= at_last ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/masked_tlb_array.sv
module masked_tlb_array
  import tlbx_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDXW = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ifetch,
  input  logic              wr_en,
  input  logic [IDXW:0]     wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              flush,
  input  logic              vic_adv,
  output logic              hit,
  output logic [IDXW:0]     hit_idx,
  output logic [PFN_W-1:0]  pfn0,
  output logic [PFN_W-1:0]  pfn1,
  output logic              uncacheable,
  output logic              align_fault,
  output logic [IDXW-1:0]   victim_idx
);
  tlb_ent_t [N_ENT-1:0] tab;
  tlb_ent_t             wr_ent;
  tlb_ent_t             sel_ent;
  logic                 match_any;
  logic [IDXW-1:0]      match_idx;
  logic [VPN_W-1:0]     lk_vpn;

  assign wr_ent = '{vpn: wr_vpn, mask: wr_mask, asid: wr_asid, glob: wr_glob,
                    v0: wr_v0, v1: wr_v1, pfn0: wr_pfn0, pfn1: wr_pfn1};
  assign lk_vpn = lk_vaddr[VA_W-1:PAGE_W];

  tlb_entry_store #(.N_ENT(N_ENT)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_ent(wr_ent), .tab(tab)
  );

  tlb_match #(.N_ENT(N_ENT)) u_match (
    .tab(tab), .vpn(lk_vpn), .asid(lk_asid), .any(match_any), .idx(match_idx)
  );

  tlb_victim_ptr #(.N_ENT(N_ENT)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(vic_adv), .ptr(victim_idx)
  );

  assign sel_ent     = tab[match_idx];
  assign align_fault = lk_ifetch & misaligned(lk_vaddr);
  assign uncacheable = is_uncached(lk_vaddr);
  assign hit         = match_any & ~align_fault;
  assign hit_idx     = match_any ? {1'b0, match_idx} : '1;
  assign pfn0        = hit ? sel_ent.pfn0 : '0;
  assign pfn1        = hit ? sel_ent.pfn1 : '0;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int N_ENT = 8,
  localparam int IDXW = $clog2(N_ENT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            vic_adv,
  input logic [IDXW-1:0] victim_idx,
  input logic [31:0]     lk_vaddr,
  input logic            lk_ifetch,
  input logic            hit,
  input logic [IDXW:0]   hit_idx,
  input logic            align_fault,
  input logic            uncacheable,
  input logic            match_any
);
  // R3: a miss in the compare stage shows the all-ones sentinel
  p_miss_sentinel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !match_any |-> (hit_idx == '1));

  // R3: a match reports a non-negative slot number
  p_match_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_any |-> (hit_idx[IDXW] == 1'b0));

  // R6: flush leaves an empty array and a zero pointer
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (victim_idx == '0) && !match_any);

  // R7: pointer wraps at the last slot
  p_victim_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && vic_adv && int'(victim_idx) == N_ENT - 1) |=> (victim_idx == '0));

  // R7: pointer holds without an advance
  p_victim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !vic_adv) |=> $stable(victim_idx));

  // R8: misaligned fetch faults and never hits
  p_fetch_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_ifetch && lk_vaddr[1:0] != 2'b00) |-> (align_fault && !hit));

  // R8: a hit implies an underlying match
  p_hit_needs_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_any);

  // R9: uncacheable only in the high region
  p_uncached_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uncacheable |-> (lk_vaddr[31] && lk_vaddr[29]));
endmodule

bind masked_tlb_array tlb_checker #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .vic_adv(vic_adv),
  .victim_idx(victim_idx), .lk_vaddr(lk_vaddr), .lk_ifetch(lk_ifetch),
  .hit(hit), .hit_idx(hit_idx), .align_fault(align_fault),
  .uncacheable(uncacheable), .match_any(match_any)
);

// File: tb/tb_masked_tlb_array.sv
module tb_masked_tlb_array;
  localparam int N = 8;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_ifetch = 1'b0;
  logic        wr_en = 1'b0;
  logic [IW:0] wr_idx = '0;
  logic [18:0] wr_vpn = '0, wr_mask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_glob = 1'b0, wr_v0 = 1'b0, wr_v1 = 1'b0;
  logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic        flush = 1'b0, vic_adv = 1'b0;
  logic        hit, uncacheable, align_fault;
  logic [IW:0] hit_idx;
  logic [19:0] pfn0, pfn1;
  logic [IW-1:0] victim_idx;

  masked_tlb_array #(.N_ENT(N)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;

  logic [18:0] m_vpn[N], m_mask[N];
  logic [7:0]  m_asid[N];
  logic        m_g[N], m_v0[N], m_v1[N];
  logic [19:0] m_p0[N], m_p1[N];
  int          m_vic = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0;
      m_v0[i] = 0; m_v1[i] = 0; m_p0[i] = '0; m_p1[i] = '0;
    end
    m_vic = 0;
  endtask

  // Expected probe: first slot whose kept bits agree, valid, tag or global.
  function automatic int exp_index(logic [31:0] va, logic [7:0] asid);
    logic [18:0] v;
    v = va[31:13];
    for (int i = 0; i < N; i++) begin
      if (!(m_v0[i] || m_v1[i])) continue;
      if (!(m_g[i] || m_asid[i] == asid)) continue;
      if ((v & ~m_mask[i]) == (m_vpn[i] & ~m_mask[i])) return i;
    end
    return -1;
  endfunction

  task automatic do_write(input int idx, input logic [18:0] vpn, input logic [18:0] msk,
                          input logic [7:0] asid, input logic g, input logic v0, input logic v1,
                          input logic [19:0] p0, input logic [19:0] p1);
    @(negedge clk);
    wr_en = 1; wr_idx = (IW+1)'(idx); wr_vpn = vpn; wr_mask = msk; wr_asid = asid;
    wr_glob = g; wr_v0 = v0; wr_v1 = v1; wr_pfn0 = p0; wr_pfn1 = p1;
    @(negedge clk);
    wr_en = 0;
    if (idx < N) begin
      m_vpn[idx] = vpn; m_mask[idx] = msk; m_asid[idx] = asid; m_g[idx] = g;
      m_v0[idx] = v0; m_v1[idx] = v1; m_p0[idx] = p0; m_p1[idx] = p1;
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    model_clear();
  endtask

  task automatic do_adv();
    @(negedge clk); vic_adv = 1;
    @(negedge clk); vic_adv = 0;
    m_vic = (m_vic + 1) % N;
    check(victim_idx == IW'(m_vic), "R7 victim advance", victim_idx, m_vic);
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic ifetch,
                      input string tag);
    int ei;
    logic ef, eh, eu;
    logic [IW:0] eidx;
    @(negedge clk);
    lk_vaddr = va; lk_asid = asid; lk_ifetch = ifetch;
    #3;
    ei = exp_index(va, asid);
    ef = ifetch && (va[0] || va[1]);
    eh = (ei >= 0) && !ef;
    eu = va[31] && va[29];
    eidx = (ei < 0) ? '1 : (IW+1)'(ei);
    check(hit == eh, {tag, " R1 R2 R4 R8 hit"}, hit, eh);
    check(hit_idx == eidx, {tag, " R3 probe index"}, hit_idx, eidx);
    check(pfn0 == (eh ? m_p0[ei] : 20'h0) && pfn1 == (eh ? m_p1[ei] : 20'h0),
          {tag, " R10 frame numbers"}, {pfn0, pfn1},
          eh ? {m_p0[ei], m_p1[ei]} : 40'h0);
    check(align_fault == ef, {tag, " R8 fault"}, align_fault, ef);
    check(uncacheable == eu, {tag, " R9 uncacheable"}, uncacheable, eu);
  endtask

  task automatic run_all();
    logic [18:0] v;
    int t;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(victim_idx == '0, "R7 reset pointer", victim_idx, 0);
    look(32'h1234_5000, 8'h01, 0, "reset");

    // R1: masked bits ignored; unmasked bit difference misses
    do_write(2, 19'h00A50, 19'h0000F, 8'h05, 0, 1, 0, 20'h11111, 20'h22222);
    look({19'h00A5C, 13'h0100}, 8'h05, 0, "R1 masked bits differ");
    look({19'h00A70, 13'h0100}, 8'h05, 0, "R1 kept bit differs");
    // R2: tag mismatch misses, then global slot matches any tag
    look({19'h00A50, 13'h0}, 8'h06, 0, "R2 wrong tag");
    do_write(5, 19'h00A50, 19'h000FF, 8'h77, 1, 0, 1, 20'h33333, 20'h44444);
    look({19'h00A50, 13'h0}, 8'h06, 0, "R2 global");
    // R3: lowest index wins over the higher global slot
    look({19'h00A51, 13'h0}, 8'h05, 0, "R3 priority");
    // R4: invalid slot with an exact page and tag never hits
    do_write(0, 19'h01234, 19'h0, 8'h09, 0, 0, 0, 20'h55555, 20'h66666);
    look({19'h01234, 13'h0}, 8'h09, 0, "R4 invalid slot");
    do_write(0, 19'h01234, 19'h0, 8'h09, 0, 0, 1, 20'h55555, 20'h66666);
    look({19'h01234, 13'h0}, 8'h09, 0, "R4 odd valid only");
    // R8: misaligned fetch versus data access to the same address
    look({19'h01234, 13'h2}, 8'h09, 1, "R8 fetch misaligned");
    look({19'h01234, 13'h1}, 8'h09, 0, "R8 data misaligned");
    look({19'h01234, 13'h4}, 8'h09, 1, "R8 fetch aligned");
    // R9: region edges
    look(32'hA000_0000, 8'h0, 0, "R9 exact pattern");
    look(32'h8000_0000, 8'h0, 0, "R9 bit29 clear");
    look(32'h2000_0000, 8'h0, 0, "R9 bit31 clear");
    // R5: out-of-range write leaves the array as it was
    do_write(N + 3, 19'h07777, 19'h0, 8'h01, 1, 1, 1, 20'hABCDE, 20'hABCDE);
    look({19'h07777, 13'h0}, 8'h01, 0, "R5 out of range");
    do_write(2, 19'h07777, 19'h0, 8'h01, 0, 1, 1, 20'h0F0F0, 20'h0A0A0);
    look({19'h00A50, 13'h0}, 8'h05, 0, "R5 replaced old page");
    look({19'h07777, 13'h0}, 8'h01, 0, "R5 replaced new page");
    // R7: step through the pointer and wrap
    for (int i = 0; i < N + 2; i++) do_adv();
    // R6: flush with a simultaneous write and advance
    @(negedge clk);
    flush = 1; vic_adv = 1; wr_en = 1; wr_idx = 1; wr_vpn = 19'h01234; wr_mask = '0;
    wr_asid = 8'h09; wr_glob = 1; wr_v0 = 1; wr_v1 = 1;
    @(negedge clk);
    flush = 0; vic_adv = 0; wr_en = 0;
    model_clear();
    check(victim_idx == '0, "R6 flush pointer", victim_idx, 0);
    look({19'h01234, 13'h0}, 8'h09, 0, "R6 after flush");
    look({19'h07777, 13'h0}, 8'h01, 0, "R6 after flush 2");

    // Random phase: small page space, few tags, short masks -> overlaps
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      t = $urandom_range(0, 9);
      if (t < 3) begin
        do_write($urandom_range(0, N + 1), 19'($urandom_range(0, 63)),
                 19'((1 << $urandom_range(0, 3)) - 1), 8'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                 20'($urandom), 20'($urandom));
      end else if (t == 3) begin
        do_adv();
      end else if (t == 4 && $urandom_range(0, 9) == 0) begin
        do_flush();
        check(victim_idx == '0, "R6 random flush pointer", victim_idx, 0);
      end else begin
        int s;
        s = $urandom_range(0, N - 1);
        v = m_vpn[s] ^ (19'($urandom) & m_mask[s]);
        if ($urandom_range(0, 4) == 0) v = 19'($urandom_range(0, 63));
        look({v[18:16] | 3'($urandom_range(0, 7) & {3{1'($urandom)}}), v[15:0],
              13'($urandom)},
             ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 3)) : m_asid[s],
             1'($urandom), "random");
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule